// File: doc/BRIEF.md
# Load/Store Address Generator

This block turns one decoded load/store command into one or two memory beats. It covers four transfer kinds: unsigned halfword, sign-extended byte load, sign-extended halfword load, and two-word transfer. The command carries a base value and an offset. The offset is either a register value or an 8-bit immediate built from two nibbles. The command also carries indexing controls and the transfer selectors. The block computes the access address and the updated base. It asks an external checker whether the address is legal. It then drives a valid/ready memory port and extends returning load data to the full width.

A two-word transfer becomes two word beats at consecutive word addresses. The second beat goes out only after the first one has completed. The register pair must start at an even register number. An illegal address or a badly formed pair ends the command without any memory traffic and without a base update. The register file and the memory behind the port are outside the block.

Top module: `ldst_agen`

## Requirements
- R1: With `cmd_imm_sel`=1 the offset is `{cmd_imm_hi, cmd_imm_lo}` (high nibble first), zero-extended. With `cmd_imm_sel`=0 the offset is `cmd_reg_off` and the nibble inputs have no effect.
- R2: With `cmd_pre`=0 the access address is the unmodified base. The base is always written back as base+offset (`cmd_up`=1) or base-offset (`cmd_up`=0), whatever `cmd_wb` is.
- R3: With `cmd_pre`=1 the access address is base+offset or base-offset, wrapping modulo 2^DW. That same value is written back only when `cmd_wb`=1.
- R4: When `chk_legal` is low during the check cycle, `fault` and `done` pulse together. No memory request follows and `wb_en` stays low.
- R5: With `cmd_signed`=0 the transfer is a halfword (`mem_size`=1). A load returns `mem_rdata[15:0]` zero-extended. A store drives the low 16 bits of `cmd_data_lo` on `mem_wdata[15:0]` with the upper bits zero.
- R6: With `cmd_signed`=1 and `cmd_load`=1, the load sign-extends `mem_rdata[15:0]` when `cmd_half`=1 (`mem_size`=1). It sign-extends `mem_rdata[7:0]` when `cmd_half`=0 (`mem_size`=0).
- R7: With `cmd_signed`=1 and `cmd_load`=0 the transfer is two word beats (`mem_size`=2). `cmd_half`=1 stores `cmd_data_lo` then `cmd_data_hi`, and `cmd_half`=0 loads into `cmd_rd` then `cmd_rd`|1. The second address is the first plus 4.
- R8: A two-word transfer whose `cmd_rd` is odd pulses `bad_op` and `done`. No memory request follows and no writeback occurs.
- R9: `mem_valid` stays high with a stable address and write data until `mem_ready`. The second beat of a pair is presented only after the first beat's handshake.
- R10: After reset `cmd_ready`=1 and `mem_valid`=0. `wb_en` and `done` pulse on the handshake of the last beat. `cmd_ready` is high only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command accepted this cycle |
| cmd_base | input | DW | Base register value |
| cmd_reg_off | input | DW | Register offset value |
| cmd_imm_sel | input | 1 | 1 selects the nibble immediate offset |
| cmd_imm_hi | input | 4 | Immediate high nibble |
| cmd_imm_lo | input | 4 | Immediate low nibble |
| cmd_pre | input | 1 | 1 applies the offset before the access |
| cmd_up | input | 1 | 1 adds the offset, 0 subtracts it |
| cmd_wb | input | 1 | Writeback request for pre-offset mode |
| cmd_load | input | 1 | Load/store selector |
| cmd_signed | input | 1 | Signed selector |
| cmd_half | input | 1 | Halfword selector |
| cmd_rd | input | RW | Data register number |
| cmd_data_lo | input | DW | Store data for the data register |
| cmd_data_hi | input | DW | Store data for the paired odd register |
| chk_addr | output | DW | Address under check |
| chk_legal | input | 1 | Checker verdict on chk_addr |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_addr | output | DW | Request address |
| mem_write | output | 1 | 1 for a store beat |
| mem_size | output | 2 | 0 byte, 1 halfword, 2 word |
| mem_wdata | output | DW | Store data |
| mem_rdata | input | DW | Load data, valid with the handshake |
| ld_en | output | 1 | Load result valid |
| ld_reg | output | RW | Register receiving the load result |
| ld_data | output | DW | Extended load result |
| wb_en | output | 1 | Base writeback strobe |
| wb_data | output | DW | New base value |
| fault | output | 1 | Illegal address pulse |
| bad_op | output | 1 | Odd-register pair pulse |
| done | output | 1 | Command finished |

## Verification
The bench builds the block with its default widths: 32-bit data and 4-bit register numbers. With 32-bit data, subtracting the offset from a small base wraps past zero. With 4-bit register numbers, the pair rule covers both an even starting register and an odd one. Stalls on `mem_ready` are inserted on single beats and on each beat of a pair, so the hold behaviour and the ordering of the two beats are both exercised.

// File: rtl/ldst_agen_pkg.sv
package ldst_agen_pkg;

    localparam int NIB_W = 4;
    localparam int IMM_W = 2 * NIB_W;

    typedef enum logic [2:0] {
        XK_UHALF,
        XK_SBYTE,
        XK_SHALF,
        XK_DLOAD,
        XK_DSTORE
    } xfer_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } mem_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_BEAT0,
        ST_BEAT1
    } seq_state_e;

    function automatic xfer_kind_e classify(input logic is_load, input logic is_signed,
                                            input logic is_half);
        if (!is_signed)   return XK_UHALF;
        else if (is_load) return is_half ? XK_SHALF : XK_SBYTE;
        else              return is_half ? XK_DSTORE : XK_DLOAD;
    endfunction

    function automatic mem_size_e kind_size(input xfer_kind_e k);
        case (k)
            XK_SBYTE:            return SZ_BYTE;
            XK_UHALF, XK_SHALF:  return SZ_HALF;
            default:             return SZ_WORD;
        endcase
    endfunction

    function automatic logic kind_is_pair(input xfer_kind_e k);
        return (k == XK_DLOAD) || (k == XK_DSTORE);
    endfunction

endpackage

// File: rtl/ldst_addr_calc.sv
module ldst_addr_calc
    import ldst_agen_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0]    base,
    input  logic [DW-1:0]    reg_off,
    input  logic             imm_sel,
    input  logic [NIB_W-1:0] imm_hi,
    input  logic [NIB_W-1:0] imm_lo,
    input  logic             pre,
    input  logic             up,
    input  logic             wb_bit,
    output logic [DW-1:0]    addr,
    output logic [DW-1:0]    new_base,
    output logic             wb_req
);
    localparam int PAD_W = DW - IMM_W;

    logic [DW-1:0] offset;
    logic [DW-1:0] moved;

    always_comb begin
        offset   = imm_sel ? {{PAD_W{1'b0}}, imm_hi, imm_lo} : reg_off;
        moved    = up ? (base + offset) : (base - offset);
        addr     = pre ? moved : base;
        new_base = moved;
        wb_req   = pre ? wb_bit : 1'b1;
    end
endmodule

// File: rtl/ldst_load_ext.sv
module ldst_load_ext
    import ldst_agen_pkg::*;
#(
    parameter int DW = 32
) (
    input  xfer_kind_e    kind,
    input  logic [DW-1:0] raw,
    output logic [DW-1:0] ext
);
    localparam int HW = 16;
    localparam int BW = 8;

    always_comb begin
        case (kind)
            XK_UHALF: ext = {{(DW-HW){1'b0}}, raw[HW-1:0]};
            XK_SHALF: ext = {{(DW-HW){raw[HW-1]}}, raw[HW-1:0]};
            XK_SBYTE: ext = {{(DW-BW){raw[BW-1]}}, raw[BW-1:0]};
            default:  ext = raw;
        endcase
    end
endmodule

// File: rtl/ldst_seq.sv
module ldst_seq
    import ldst_agen_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic       chk_legal,
    input  logic       is_pair,
    input  logic       rd_odd,
    input  logic       mem_ready,
    output seq_state_e state,
    output logic       cmd_ready,
    output logic       mem_valid,
    output logic       second,
    output logic       fault,
    output logic       bad_op,
    output logic       beat_hs,
    output logic       last_hs
);
    seq_state_e nxt;

    always_comb begin
        cmd_ready = (state == ST_IDLE);
        mem_valid = (state == ST_BEAT0) || (state == ST_BEAT1);
        second    = (state == ST_BEAT1);
        fault     = (state == ST_CHECK) && !chk_legal;
        bad_op    = (state == ST_CHECK) && chk_legal && is_pair && rd_odd;
        beat_hs   = mem_valid && mem_ready;
        last_hs   = beat_hs && (second || !is_pair);
        nxt       = state;
        case (state)
            ST_IDLE:  if (cmd_valid) nxt = ST_CHECK;
            ST_CHECK: nxt = (fault || bad_op) ? ST_IDLE : ST_BEAT0;
            ST_BEAT0: if (mem_ready) nxt = is_pair ? ST_BEAT1 : ST_IDLE;
            ST_BEAT1: if (mem_ready) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // R4
    fault_idle_chk: assert property (@(posedge clk) disable iff (rst)
        fault |=> (cmd_ready && !mem_valid));

    // R8
    bad_op_idle_chk: assert property (@(posedge clk) disable iff (rst)
        bad_op |=> (cmd_ready && !mem_valid));

    // R9
    pair_order_chk: assert property (@(posedge clk) disable iff (rst)
        (second) |-> $past(mem_valid));
endmodule

// File: rtl/ldst_agen.sv
module ldst_agen
    import ldst_agen_pkg::*;
#(
    parameter int DW = 32,
    parameter int RW = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [DW-1:0]    cmd_base,
    input  logic [DW-1:0]    cmd_reg_off,
    input  logic             cmd_imm_sel,
    input  logic [3:0]       cmd_imm_hi,
    input  logic [3:0]       cmd_imm_lo,
    input  logic             cmd_pre,
    input  logic             cmd_up,
    input  logic             cmd_wb,
    input  logic             cmd_load,
    input  logic             cmd_signed,
    input  logic             cmd_half,
    input  logic [RW-1:0]    cmd_rd,
    input  logic [DW-1:0]    cmd_data_lo,
    input  logic [DW-1:0]    cmd_data_hi,
    output logic [DW-1:0]    chk_addr,
    input  logic             chk_legal,
    output logic             mem_valid,
    input  logic             mem_ready,
    output logic [DW-1:0]    mem_addr,
    output logic             mem_write,
    output logic [1:0]       mem_size,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    output logic             ld_en,
    output logic [RW-1:0]    ld_reg,
    output logic [DW-1:0]    ld_data,
    output logic             wb_en,
    output logic [DW-1:0]    wb_data,
    output logic             fault,
    output logic             bad_op,
    output logic             done
);
    localparam int          STEP  = DW / 8;
    localparam logic [DW-1:0] STEP_V = DW'(STEP);
    localparam int          HW    = 16;

    typedef struct packed {
        logic [DW-1:0] addr;
        logic [DW-1:0] new_base;
        logic          wb;
        logic          write;
        xfer_kind_e    kind;
        logic [RW-1:0] rd;
        logic [DW-1:0] d_lo;
        logic [DW-1:0] d_hi;
    } op_t;

    op_t           op_q;
    logic [DW-1:0] c_addr, c_nb;
    logic          c_wb;
    xfer_kind_e    c_kind;
    seq_state_e    state;
    logic          second, beat_hs, last_hs, is_pair;

    ldst_addr_calc #(.DW(DW)) u_calc (
        .base(cmd_base), .reg_off(cmd_reg_off), .imm_sel(cmd_imm_sel),
        .imm_hi(cmd_imm_hi), .imm_lo(cmd_imm_lo), .pre(cmd_pre), .up(cmd_up),
        .wb_bit(cmd_wb), .addr(c_addr), .new_base(c_nb), .wb_req(c_wb)
    );

    assign c_kind  = classify(cmd_load, cmd_signed, cmd_half);
    assign is_pair = kind_is_pair(op_q.kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q <= '0;
        end else if (cmd_valid && cmd_ready) begin
            op_q.addr     <= c_addr;
            op_q.new_base <= c_nb;
            op_q.wb       <= c_wb;
            op_q.write    <= (c_kind == XK_DSTORE) || (c_kind == XK_UHALF && !cmd_load);
            op_q.kind     <= c_kind;
            op_q.rd       <= cmd_rd;
            op_q.d_lo     <= cmd_data_lo;
            op_q.d_hi     <= cmd_data_hi;
        end
    end

    ldst_seq u_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .chk_legal(chk_legal),
        .is_pair(is_pair), .rd_odd(op_q.rd[0]), .mem_ready(mem_ready),
        .state(state), .cmd_ready(cmd_ready), .mem_valid(mem_valid),
        .second(second), .fault(fault), .bad_op(bad_op),
        .beat_hs(beat_hs), .last_hs(last_hs)
    );

    ldst_load_ext #(.DW(DW)) u_ext (
        .kind(op_q.kind), .raw(mem_rdata), .ext(ld_data)
    );

    always_comb begin
        chk_addr  = op_q.addr;
        mem_addr  = second ? (op_q.addr + STEP_V) : op_q.addr;
        mem_write = op_q.write;
        mem_size  = kind_size(op_q.kind);
        if (op_q.kind == XK_UHALF)
            mem_wdata = op_q.write ? {{(DW-HW){1'b0}}, op_q.d_lo[HW-1:0]} : '0;
        else if (op_q.kind == XK_DSTORE)
            mem_wdata = second ? op_q.d_hi : op_q.d_lo;
        else
            mem_wdata = '0;
        ld_en   = beat_hs && !op_q.write;
        ld_reg  = second ? {op_q.rd[RW-1:1], 1'b1} : op_q.rd;
        wb_en   = last_hs && op_q.wb;
        wb_data = op_q.new_base;
        done    = last_hs || fault || bad_op;
    end

    // R9
    hold_req_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata)));

    // R7
    pair_step_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_hs && is_pair && !second) |=> (mem_valid && mem_addr == $past(mem_addr) + STEP_V));

    // R10
    wb_on_beat_chk: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (mem_valid && mem_ready && !fault && !bad_op));

    // R4
    fault_no_traffic_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> (!mem_valid && !wb_en && !ld_en && state == ST_CHECK));
endmodule

// File: tb/ldst_agen_test.sv
module ldst_agen_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int RW = 4;

    logic clk = 0, rst = 1;
    logic cmd_valid = 0, cmd_ready;
    logic [DW-1:0] cmd_base = 0, cmd_reg_off = 0, cmd_data_lo = 0, cmd_data_hi = 0;
    logic cmd_imm_sel = 0, cmd_pre = 0, cmd_up = 0, cmd_wb = 0;
    logic cmd_load = 0, cmd_signed = 0, cmd_half = 0;
    logic [3:0] cmd_imm_hi = 0, cmd_imm_lo = 0;
    logic [RW-1:0] cmd_rd = 0;
    logic [DW-1:0] chk_addr, mem_addr, mem_wdata, ld_data, wb_data;
    logic [DW-1:0] mem_rdata = 0;
    logic chk_legal = 1, mem_ready = 0;
    logic mem_valid, mem_write, ld_en, wb_en, fault, bad_op, done;
    logic [1:0] mem_size;
    logic [RW-1:0] ld_reg;

    int vectors = 0, fails = 0;

    // observations of one command
    int nb, ld_cnt, wb_cnt;
    logic [DW-1:0] a_obs[2], wd_obs[2], ld_obs[2];
    logic w_obs[2];
    logic [1:0] sz_obs[2];
    logic [RW-1:0] lr_obs[2];
    logic [DW-1:0] wb_val;
    logic fault_seen, bad_seen, hold_ok;

    ldst_agen #(.DW(DW), .RW(RW)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic set_cmd(input logic [DW-1:0] base, input logic [DW-1:0] roff,
                           input logic isel, input logic [3:0] hi, input logic [3:0] lo,
                           input logic pre, input logic up, input logic wb,
                           input logic ld, input logic sg, input logic hf,
                           input logic [RW-1:0] rd);
        cmd_base = base; cmd_reg_off = roff; cmd_imm_sel = isel;
        cmd_imm_hi = hi; cmd_imm_lo = lo; cmd_pre = pre; cmd_up = up; cmd_wb = wb;
        cmd_load = ld; cmd_signed = sg; cmd_half = hf; cmd_rd = rd;
    endtask

    task automatic run(input logic legal, input logic [DW-1:0] r0, input logic [DW-1:0] r1,
                       input int stall0, input int stall1);
        int stalls;
        logic fin, was_stall;
        logic [DW-1:0] prev_a;
        nb = 0; ld_cnt = 0; wb_cnt = 0; fault_seen = 0; bad_seen = 0; hold_ok = 1;
        stalls = 0; fin = 0; was_stall = 0; prev_a = '0;
        @(negedge clk);
        cmd_valid = 1; chk_legal = legal;
        @(posedge clk);
        #1 cmd_valid = 0;
        for (int cyc = 0; cyc < 30 && !fin; cyc++) begin
            @(negedge clk);
            if (mem_valid && nb < 2) begin
                if (was_stall && mem_addr !== prev_a) hold_ok = 0;
                if (stalls < ((nb == 0) ? stall0 : stall1)) begin
                    stalls++; was_stall = 1; prev_a = mem_addr;
                end else begin
                    mem_ready = 1; mem_rdata = (nb == 0) ? r0 : r1;
                    was_stall = 0;
                end
            end else if (was_stall) begin
                hold_ok = 0; was_stall = 0;
            end
            #1;
            if (fault) fault_seen = 1;
            if (bad_op) bad_seen = 1;
            if (wb_en) begin wb_cnt++; wb_val = wb_data; end
            if (mem_valid && mem_ready) begin
                a_obs[nb] = mem_addr; wd_obs[nb] = mem_wdata;
                w_obs[nb] = mem_write; sz_obs[nb] = mem_size;
                if (ld_en) begin ld_cnt++; ld_obs[nb] = ld_data; lr_obs[nb] = ld_reg; end
                nb++; stalls = 0;
            end
            if (done) fin = 1;
            @(posedge clk);
            #1 mem_ready = 0;
        end
        if (!fin) chk("command never finished", 0, 1);
    endtask

    task automatic t_reset;
        chk("R10 cmd_ready after reset", DW'(cmd_ready), 1);
        chk("R10 mem_valid after reset", DW'(mem_valid), 0);
    endtask

    task automatic t_uhalf_load_post;
        // R1 R2 R5: post-offset, subtract immediate 0xA5, forced writeback
        set_cmd(32'h1000, 32'h7777, 1, 4'hA, 4'h5, 0, 0, 0, 1, 0, 0, 4'd3);
        run(1, 32'hDEAD8001, 0, 0, 0);
        chk("R2 address is base", a_obs[0], 32'h1000);
        chk("R1 R2 writeback base-imm", wb_val, 32'h0F5B);
        chk("R2 writeback forced", DW'(wb_cnt), 1);
        chk("R5 zero-extended load", ld_obs[0], 32'h00008001);
        chk("R5 halfword size", DW'(sz_obs[0]), 1);
        chk("R5 load register", DW'(lr_obs[0]), 3);
    endtask

    task automatic t_uhalf_store_pre;
        // R1 R3 R5 R9: register offset, nibbles ignored, no writeback, stalled beat
        set_cmd(32'h2000, 32'h30, 0, 4'hF, 4'hF, 1, 1, 0, 0, 0, 0, 4'd1);
        cmd_data_lo = 32'h1234BEEF;
        run(1, 0, 0, 2, 0);
        chk("R1 R3 register offset address", a_obs[0], 32'h2030);
        chk("R3 no writeback without wb bit", DW'(wb_cnt), 0);
        chk("R5 store low half only", wd_obs[0], 32'h0000BEEF);
        chk("R5 store is write", DW'(w_obs[0]), 1);
        chk("R5 store no load result", DW'(ld_cnt), 0);
        chk("R9 request held during stall", DW'(hold_ok), 1);
    endtask

    task automatic t_signed_loads;
        // R3 R6: signed halfword, pre-offset add immediate 4 with writeback
        set_cmd(32'h100, 0, 1, 4'h0, 4'h4, 1, 1, 1, 1, 1, 1, 4'd6);
        run(1, 32'h0000F00F, 0, 0, 0);
        chk("R3 pre-offset address", a_obs[0], 32'h104);
        chk("R3 writeback with wb bit", wb_val, 32'h104);
        chk("R6 halfword sign extension", ld_obs[0], 32'hFFFFF00F);
        // R6: signed byte negative, pre-offset subtract register
        set_cmd(32'h50, 32'h10, 0, 0, 0, 1, 0, 1, 1, 1, 0, 4'd2);
        run(1, 32'h12345680, 0, 0, 0);
        chk("R6 byte address", a_obs[0], 32'h40);
        chk("R6 byte sign extension negative", ld_obs[0], 32'hFFFFFF80);
        chk("R6 byte size", DW'(sz_obs[0]), 0);
        // R6: signed byte positive, post-offset add register
        set_cmd(32'h80, 32'h8, 0, 0, 0, 0, 1, 0, 1, 1, 0, 4'd2);
        run(1, 32'hABCDEF7F, 0, 0, 0);
        chk("R6 byte positive", ld_obs[0], 32'h0000007F);
        chk("R2 post add writeback", wb_val, 32'h88);
    endtask

    task automatic t_pair_load;
        // R7 R9 R10: pair load, post-offset add immediate 8
        set_cmd(32'h3000, 0, 1, 4'h0, 4'h8, 0, 1, 0, 0, 1, 0, 4'd4);
        run(1, 32'hAAAA0001, 32'hBBBB0002, 1, 1);
        chk("R7 beat count", DW'(nb), 2);
        chk("R7 first address", a_obs[0], 32'h3000);
        chk("R7 second address plus 4", a_obs[1], 32'h3004);
        chk("R7 first register", DW'(lr_obs[0]), 4);
        chk("R7 second register", DW'(lr_obs[1]), 5);
        chk("R7 first data", ld_obs[0], 32'hAAAA0001);
        chk("R7 second data", ld_obs[1], 32'hBBBB0002);
        chk("R7 word size", DW'(sz_obs[1]), 2);
        chk("R10 single writeback", DW'(wb_cnt), 1);
        chk("R10 writeback value", wb_val, 32'h3008);
        chk("R9 pair held during stalls", DW'(hold_ok), 1);
    endtask

    task automatic t_pair_store;
        // R7 R9: pair store, pre-offset subtract immediate 0x10 with writeback
        set_cmd(32'h4010, 0, 1, 4'h1, 4'h0, 1, 0, 1, 0, 1, 1, 4'd2);
        cmd_data_lo = 32'h11112222; cmd_data_hi = 32'h33334444;
        run(1, 0, 0, 0, 3);
        chk("R7 store first address", a_obs[0], 32'h4000);
        chk("R7 store second address", a_obs[1], 32'h4004);
        chk("R7 store first data", wd_obs[0], 32'h11112222);
        chk("R7 store second data", wd_obs[1], 32'h33334444);
        chk("R7 store writes", DW'({w_obs[0], w_obs[1]}), 3);
        chk("R7 store no load result", DW'(ld_cnt), 0);
        chk("R3 store writeback", wb_val, 32'h4000);
        chk("R9 second beat held", DW'(hold_ok), 1);
    endtask

    task automatic t_illegal;
        // R4: post-offset would force writeback, address illegal
        set_cmd(32'h5000, 32'h4, 0, 0, 0, 0, 1, 1, 1, 0, 0, 4'd1);
        run(0, 0, 0, 0, 0);
        chk("R4 fault raised", DW'(fault_seen), 1);
        chk("R4 no memory beat", DW'(nb), 0);
        chk("R4 no writeback", DW'(wb_cnt), 0);
        chk("R4 checker saw address", chk_addr, 32'h5000);
    endtask

    task automatic t_odd_pair;
        // R8: pair load starting at odd register 7
        set_cmd(32'h6000, 0, 1, 0, 4'h8, 0, 1, 0, 0, 1, 0, 4'd7);
        run(1, 0, 0, 0, 0);
        chk("R8 bad_op raised", DW'(bad_seen), 1);
        chk("R8 no memory beat", DW'(nb), 0);
        chk("R8 no writeback", DW'(wb_cnt), 0);
        chk("R8 no fault", DW'(fault_seen), 0);
    endtask

    task automatic t_wrap;
        // R3: subtract past zero wraps
        set_cmd(32'h4, 0, 1, 4'h1, 4'h0, 1, 0, 1, 1, 0, 0, 4'd0);
        run(1, 32'h0000FFFF, 0, 0, 0);
        chk("R3 wrapped address", a_obs[0], 32'hFFFFFFF4);
        chk("R3 wrapped writeback", wb_val, 32'hFFFFFFF4);
        chk("R10 idle after command", DW'(cmd_ready), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        @(negedge clk);
        t_reset();
        t_uhalf_load_post();
        t_uhalf_store_pre();
        t_signed_loads();
        t_pair_load();
        t_pair_store();
        t_illegal();
        t_odd_pair();
        t_wrap();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule